// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of five clock sources drives the system clock, and when that choice may change. Software asks for a source with a 3-bit select code. The controller compares the request against the per-source stable status inputs. A request for a stable source is committed after a short window in which every source enable is held off, so the clock mux never receives a partial pulse. A request for an unstable source, or for an unassigned code, is refused. In that case the old source stays in force and a sticky failure flag is raised. Software clears the flag by writing 1.

The selected source then passes through a divider with a 4-bit field N. The divider is modelled as a clock-enable tick that fires once every N+1 source cycles. The divider holds and restarts while a switch is in progress. On every reset, the select is reloaded from a configuration input, so the system starts on either the high-speed crystal or the fast RC oscillator. Clock generation itself and the glitch-free analog mux sit outside this block. The one-hot source enables model the handshake with that mux.

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: While reset is low and after it is released, active_sel equals 3'b111 when cfg_use_rc is 1 and 3'b000 when it is 0. switch_fail is 0, switch_busy is 0 and div_n is 0.
- R2: Outside a switch, src_gate_en is one-hot and follows the active code: 000 drives bit 0 (high-speed crystal), 001 drives bit 1 (32.768 kHz crystal), 010 drives bit 2 (PLL), 011 drives bit 3 (10 kHz RC) and 111 drives bit 4 (22.1184 MHz RC).
- R3: A select write is accepted when its code is assigned and src_stable of the target is 1. After that edge, switch_busy is 1 and src_gate_en is all zero for exactly 2 cycles. switch_fail reads 0. On the third edge, active_sel takes the new code and busy drops.
- R4: A select write to an assigned code whose src_stable bit is 0 sets switch_fail at the next edge. active_sel does not change and no gating window starts.
- R5: Codes 100, 101 and 110 are refused in the same way as an unstable target: switch_fail is set and active_sel is kept.
- R6: A fail_clr pulse clears switch_fail. When a select write lands in the same cycle, the switch outcome decides the flag.
- R7: A select write arriving while switch_busy is 1 is ignored. The pending switch completes to its own target, and switch_fail is left unchanged.
- R8: After a divider write of N, sys_tick is 1 on the N-th cycle after the write edge, and then once every N+1 cycles. N = 0 gives a tick every cycle.
- R9: sys_tick is 0 throughout a switch window. The divider count restarts from zero once the window ends.
- R10: switch_fail stays set across cycles with no select write and no fail_clr.
- R11: src_gate_en never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low reset |
| cfg_use_rc | input | 1 | Configuration: reset default is the fast RC (1) or the high-speed crystal (0) |
| src_stable | input | 5 | Per-source stable status, bit order as in R2 |
| sel_wr_en | input | 1 | Select write strobe |
| sel_wr_data | input | 3 | Requested select code |
| fail_clr | input | 1 | Write-1-clear strobe for the failure flag |
| div_wr_en | input | 1 | Divider write strobe |
| div_wr_data | input | 4 | Divider field N |
| active_sel | output | 3 | Committed select code |
| src_gate_en | output | 5 | One-hot enable to the clock mux, all zero while switching |
| switch_busy | output | 1 | Gating window in progress |
| switch_fail | output | 1 | Sticky switch-failure flag |
| div_n | output | 4 | Current divider field |
| sys_tick | output | 1 | System clock enable at source/(N+1) |

## Verification
The assertions assume three things about the inputs. Strobes and status inputs change only between clock edges. src_stable is sampled only in the cycle of a select write. Each strobe lasts one cycle. The bench drives every input on the falling edge and raises each strobe for a single cycle. It draws random codes from all eight values and random stable masks, so accepted, unstable and reserved requests all occur. Directed cases cover a write during the window and a clear that collides with a refusal.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NSRC = 5;

  typedef enum logic [2:0] {
    SEL_HXT = 3'b000,
    SEL_LXT = 3'b001,
    SEL_PLL = 3'b010,
    SEL_LRC = 3'b011,
    SEL_HRC = 3'b111
  } clk_sel_e;

  // true for the five assigned select codes
  function automatic logic sel_legal(input logic [2:0] code);
    return (code inside {SEL_HXT, SEL_LXT, SEL_PLL, SEL_LRC, SEL_HRC});
  endfunction

  // source slot (bit position in status and enable vectors) of a code
  function automatic logic [2:0] sel_slot(input logic [2:0] code);
    case (code)
      SEL_HXT: return 3'd0;
      SEL_LXT: return 3'd1;
      SEL_PLL: return 3'd2;
      SEL_LRC: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // divider wraps when the count reaches the field value
  function automatic logic div_wrap(input logic [3:0] cnt, input logic [3:0] n);
    return cnt == n;
  endfunction
endpackage

// File: rtl/sysclk_sel_decoder.sv
module sysclk_sel_decoder
  import sysclk_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [2:0]   code,
  output logic [N-1:0] onehot
);
  always_comb begin
    onehot = '0;
    for (int i = 0; i < N; i++)
      if (32'(sel_slot(code)) == i) onehot[i] = 1'b1;
  end
endmodule

// File: rtl/sysclk_switch_fsm.sv
module sysclk_switch_fsm
  import sysclk_pkg::*;
#(
  parameter int GATE_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_use_rc,
  input  logic [NSRC-1:0] src_stable,
  input  logic            sel_wr_en,
  input  logic [2:0]      sel_wr_data,
  input  logic            fail_clr,
  output logic [2:0]      active_sel,
  output logic            busy,
  output logic            fail,
  output logic            accept_evt,
  output logic            refuse_evt
);
  localparam int CW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;

  logic [CW-1:0] gate_cnt;
  logic [2:0]    pend_sel;
  logic          tgt_ok;

  assign tgt_ok     = sel_legal(sel_wr_data) && src_stable[sel_slot(sel_wr_data)];
  assign accept_evt = sel_wr_en && !busy && tgt_ok;
  assign refuse_evt = sel_wr_en && !busy && !tgt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_sel <= cfg_use_rc ? SEL_HRC : SEL_HXT;
      pend_sel   <= '0;
      gate_cnt   <= '0;
      busy       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      if (accept_evt) begin
        pend_sel <= sel_wr_data;
        gate_cnt <= CW'(GATE_CYCLES - 1);
        busy     <= 1'b1;
        fail     <= 1'b0;
      end else if (refuse_evt) begin
        fail <= 1'b1;
      end else if (fail_clr) begin
        fail <= 1'b0;
      end
      if (busy) begin
        if (gate_cnt == '0) begin
          active_sel <= pend_sel;
          busy       <= 1'b0;
        end else begin
          gate_cnt <= gate_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             div_wr_en,
  input  logic [DIV_W-1:0] div_wr_data,
  output logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = div_wrap(4'(cnt), 4'(div_n));
  assign tick = !hold && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_n <= '0;
      cnt   <= '0;
    end else if (div_wr_en) begin
      div_n <= div_wr_data;
      cnt   <= '0;
    end else if (hold || wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
  import sysclk_pkg::*;
#(
  parameter int GATE_CYCLES = 2,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_use_rc,
  input  logic [NSRC-1:0]  src_stable,
  input  logic             sel_wr_en,
  input  logic [2:0]       sel_wr_data,
  input  logic             fail_clr,
  input  logic             div_wr_en,
  input  logic [DIV_W-1:0] div_wr_data,
  output logic [2:0]       active_sel,
  output logic [NSRC-1:0]  src_gate_en,
  output logic             switch_busy,
  output logic             switch_fail,
  output logic [DIV_W-1:0] div_n,
  output logic             sys_tick
);
  logic            accept_evt;
  logic            refuse_evt;
  logic [NSRC-1:0] act_onehot;

  sysclk_switch_fsm #(.GATE_CYCLES(GATE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_use_rc (cfg_use_rc),
    .src_stable (src_stable),
    .sel_wr_en  (sel_wr_en),
    .sel_wr_data(sel_wr_data),
    .fail_clr   (fail_clr),
    .active_sel (active_sel),
    .busy       (switch_busy),
    .fail       (switch_fail),
    .accept_evt (accept_evt),
    .refuse_evt (refuse_evt)
  );

  sysclk_sel_decoder #(.N(NSRC)) u_dec (
    .code  (active_sel),
    .onehot(act_onehot)
  );

  assign src_gate_en = switch_busy ? '0 : act_onehot;

  sysclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (switch_busy),
    .div_wr_en  (div_wr_en),
    .div_wr_data(div_wr_data),
    .div_n      (div_n),
    .tick       (sys_tick)
  );
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk
  import sysclk_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_stable,
  input logic            sel_wr_en,
  input logic [2:0]      sel_wr_data,
  input logic            fail_clr,
  input logic [2:0]      active_sel,
  input logic [NSRC-1:0] src_gate_en,
  input logic            switch_busy,
  input logic            switch_fail,
  input logic            sys_tick
);
  // R11
  gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_gate_en));

  // R3
  gate_off_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_busy |-> (src_gate_en == '0));

  // R4
  refuse_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr_en && !switch_busy && !(sel_legal(sel_wr_data) && src_stable[sel_slot(sel_wr_data)]))
      |=> (switch_fail && $stable(active_sel)));

  // R3
  sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_sel) |-> $fell(switch_busy));

  // R9
  no_tick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_busy |-> !sys_tick);

  // R10
  fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switch_fail) |-> $past(sel_wr_en));

  // R6
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_clr && !sel_wr_en) |=> !switch_fail);
endmodule

bind sysclk_switch_ctrl sysclk_switch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_stable (src_stable),
  .sel_wr_en  (sel_wr_en),
  .sel_wr_data(sel_wr_data),
  .fail_clr   (fail_clr),
  .active_sel (active_sel),
  .src_gate_en(src_gate_en),
  .switch_busy(switch_busy),
  .switch_fail(switch_fail),
  .sys_tick   (sys_tick)
);

// File: tb/sysclk_switch_ctrl_tb.sv
module sysclk_switch_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_use_rc = 1;
  logic [4:0] src_stable = '1;
  logic       sel_wr_en = 0;
  logic [2:0] sel_wr_data = 0;
  logic       fail_clr = 0;
  logic       div_wr_en = 0;
  logic [3:0] div_wr_data = 0;
  logic [2:0] active_sel;
  logic [4:0] src_gate_en;
  logic       switch_busy, switch_fail, sys_tick;
  logic [3:0] div_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [2:0] exp_sel;
  bit exp_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_use_rc(cfg_use_rc), .src_stable(src_stable),
    .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data), .fail_clr(fail_clr),
    .div_wr_en(div_wr_en), .div_wr_data(div_wr_data), .active_sel(active_sel),
    .src_gate_en(src_gate_en), .switch_busy(switch_busy), .switch_fail(switch_fail),
    .div_n(div_n), .sys_tick(sys_tick)
  );

  function automatic bit tb_legal(logic [2:0] c);
    return (c <= 3'd3) || (c == 3'd7);
  endfunction

  function automatic logic [4:0] tb_enable(logic [2:0] c);
    if (c == 3'd7) return 5'b10000;
    return 5'b00001 << c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick_edge();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(bit rc);
    @(negedge clk);
    rst_n = 0; cfg_use_rc = rc;
    #2;
    chk(active_sel == (rc ? 3'd7 : 3'd0), "R1", "sel in reset", active_sel, rc ? 7 : 0);
    @(negedge clk); rst_n = 1;
    tick_edge();
    chk(active_sel == (rc ? 3'd7 : 3'd0), "R1", "sel after reset", active_sel, rc ? 7 : 0);
    chk(!switch_fail && !switch_busy && div_n == 0, "R1", "flags/div", {switch_fail, switch_busy, div_n}, 0);
    chk(src_gate_en == tb_enable(active_sel), "R2", "enable after reset", src_gate_en, tb_enable(active_sel));
    exp_sel = rc ? 3'd7 : 3'd0; exp_fail = 0;
  endtask

  // one select write with given stable mask and clear strobe; checks outcome
  task automatic do_write(logic [2:0] code, logic [4:0] mask, bit clr);
    bit ok;
    @(negedge clk);
    src_stable = mask; sel_wr_en = 1; sel_wr_data = code; fail_clr = clr;
    ok = tb_legal(code) && mask[(code == 3'd7) ? 4 : code];
    tick_edge();
    sel_wr_en = 0; fail_clr = 0;
    if (ok) begin
      exp_fail = 0;
      chk(switch_busy && src_gate_en == 0, "R3", "gated window 1", src_gate_en, 0);
      chk(!sys_tick, "R9", "no tick in window", sys_tick, 0);
      chk(switch_fail == 0, "R3", "fail cleared on accept", switch_fail, 0);
      tick_edge();
      chk(switch_busy && src_gate_en == 0, "R3", "gated window 2", src_gate_en, 0);
      tick_edge();
      exp_sel = code;
      chk(!switch_busy && active_sel == exp_sel, "R3", "committed sel", active_sel, exp_sel);
      chk(src_gate_en == tb_enable(exp_sel), "R2", "enable map", src_gate_en, tb_enable(exp_sel));
    end else begin
      exp_fail = 1;
      chk(switch_fail == 1, tb_legal(code) ? "R4" : "R5", "fail set", switch_fail, 1);
      chk(active_sel == exp_sel && !switch_busy, tb_legal(code) ? "R4" : "R5", "sel kept", active_sel, exp_sel);
      chk($countones(src_gate_en) <= 1, "R11", "onehot", src_gate_en, tb_enable(exp_sel));
    end
  endtask

  task automatic check_div(logic [3:0] n);
    int cnt;
    int first;
    @(negedge clk); div_wr_en = 1; div_wr_data = n;
    tick_edge(); div_wr_en = 0;
    cnt = 0; first = -1;
    for (int i = 0; i < 4 * (n + 1); i++) begin
      if (sys_tick) begin
        cnt++;
        if (first < 0) first = i;
      end
      if (i != 4 * n + 3) tick_edge();
    end
    chk(div_n == n, "R8", "div field", div_n, n);
    chk(first == n, "R8", "first tick position", first, n);
    chk(cnt == 4, "R8", "ticks per 4 periods", cnt, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (2) @(posedge clk);
    do_reset(1);
    do_reset(0);

    // R2 / R3: walk each assigned code
    do_write(3'd1, 5'b11111, 0);
    do_write(3'd2, 5'b11111, 0);
    do_write(3'd3, 5'b11111, 0);
    do_write(3'd7, 5'b11111, 0);
    do_write(3'd0, 5'b11111, 0);
    // R4: unstable target
    do_write(3'd2, 5'b11011, 0);
    // R10: flag holds
    repeat (5) tick_edge();
    chk(switch_fail == 1, "R10", "sticky fail", switch_fail, 1);
    // R6: clear
    @(negedge clk); fail_clr = 1; tick_edge(); fail_clr = 0;
    chk(switch_fail == 0, "R6", "clear by write 1", switch_fail, 0);
    exp_fail = 0;
    // R5: reserved codes
    do_write(3'd4, 5'b11111, 0);
    do_write(3'd5, 5'b11111, 0);
    do_write(3'd6, 5'b11111, 1); // R6: clear loses to refusal
    chk(switch_fail == 1, "R6", "refusal beats clear", switch_fail, 1);
    // R7: write during window ignored
    @(negedge clk); sel_wr_en = 1; sel_wr_data = 3'd1; src_stable = '1;
    tick_edge(); sel_wr_en = 0;
    @(negedge clk); sel_wr_en = 1; sel_wr_data = 3'd5;
    tick_edge(); sel_wr_en = 0;
    tick_edge();
    chk(active_sel == 3'd1 && switch_fail == 0, "R7", "busy write ignored", active_sel, 1);
    exp_sel = 3'd1; exp_fail = 0;

    // R8: divider
    check_div(4'd0);
    check_div(4'd3);
    check_div(4'd15);
    // R9: restart after switch
    @(negedge clk); div_wr_en = 1; div_wr_data = 4'd2; tick_edge(); div_wr_en = 0;
    do_write(3'd7, 5'b11111, 0);
    chk(!sys_tick, "R9", "count restarted (c0)", sys_tick, 0);
    tick_edge(); tick_edge();
    chk(sys_tick, "R9", "first tick after restart", sys_tick, 1);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [2:0] c;
      logic [4:0] m;
      c = 3'($urandom_range(0, 7));
      m = 5'($urandom);
      do_write(c, m, 1'($urandom_range(0, 1)));
      chk(switch_fail == exp_fail, "R4", "random fail flag", switch_fail, exp_fail);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule